// File: doc/BRIEF.md
# Capture/Reload Sixteen-Bit Timer

This block is an up-counting timer/counter with a capture/reload register pair, a control register that also holds two event flags, and an interrupt request. The count advances either on a prescaled internal tick (timer mode) or on falling edges of an external count pin (counter mode). The capture/reload pair is used in one of three ways. In reload use, the counter is preloaded from the pair on overflow. In capture use, a falling edge on an external trigger pin stores the running count into the pair. In baud use, the counter is a programmable divider whose overflows drive a one-cycle tick toward a serial port.

A small mode state machine follows the control register one cycle later. Its states are ST_STOP, ST_RELOAD, ST_CAPTURE and ST_BAUD, and it takes one of four transitions from any state on every cycle:
- to_stop: the run bit is clear.
- to_baud: the run bit is set and either serial-clock bit is set.
- to_capture: the run bit is set, no serial-clock bit is set and the capture select bit is set.
- to_reload: every other case.

The state drives a set of per-mode controls used by the counting datapath. Both external pins pass through a two-flop synchroniser followed by a falling-edge detector. Software reads and writes every register through a byte-wide port, and `rd_data` reflects `addr` combinationally.

Top module: `cr_timer`

## Requirements
- R1: After reset the counter, the capture pair and the control register all read 0, and `ovf_flag`, `ext_flag`, `irq` and `baud_tick` are low.
- R1 (address map and reads): address 0 is control, 1 and 2 are the count low and high bytes, 3 and 4 are the capture low and high bytes, and any other address reads 0.
- R1 (control bit positions): bit0 is run, bit1 is counter mode, bit2 is capture select, bit3 is trigger enable, bit4 is receive clock, bit5 is transmit clock, bit6 is the overflow flag and bit7 is the external flag.
- R2: While the run bit is clear, the counter holds its value whatever happens on the tick or pins.
- R3: With counter mode at 0, the count advances by one for each cycle in which `tick` is high. With counter mode at 1, it advances by one for each falling edge of `cnt_pin`, and `tick` is ignored.
- R4: In reload use (run=1, capture select=0, no serial-clock bit), a step from all ones loads the capture pair into the counter and sets the overflow flag.
- R5: In capture use (run=1, capture select=1, trigger enable=1, no serial-clock bit), a falling edge on `trig_pin` copies the current count into the capture pair and sets the external flag, and counting continues. A step from all ones wraps the count to 0 and sets the overflow flag.
- R6: In reload use with trigger enable=1, a falling edge on `trig_pin` loads the capture pair into the counter and sets the external flag.
- R7: With trigger enable=0, `trig_pin` has no effect: no capture, no reload and no flag.
- R8: With the receive-clock or transmit-clock bit set, the block behaves as follows. Capture select is ignored, every overflow reloads the counter and pulses `baud_tick` high for one cycle, the overflow flag is not set, and `trig_pin` has no effect.
- R9: Both flags stay set until software writes 0 to their bit in the control register.
- R10: `irq` is high exactly when `irq_en` is high and at least one flag is set.
- R11: When a trigger edge and a step from all ones fall in the same cycle, both flags are set. In reload use the counter takes the capture pair. In capture use, the capture pair takes all ones and the counter wraps to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Prescaled internal count tick, one cycle per step |
| cnt_pin | input | 1 | External count pin (asynchronous) |
| trig_pin | input | 1 | External capture/reload trigger pin (asynchronous) |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address for read and write |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Register read data for `addr` |
| irq_en | input | 1 | Interrupt request enable |
| ovf_flag | output | 1 | Overflow flag (control bit6) |
| ext_flag | output | 1 | External trigger flag (control bit7) |
| irq | output | 1 | Interrupt request |
| baud_tick | output | 1 | One-cycle pulse per overflow in baud use |

## Verification
The two functions that can coincide are the trigger-driven capture or reload and the counter overflow. This happens when a synchronised falling edge on the trigger pin arrives in the same cycle as a tick that steps the count out of all ones. The bench loads the counter with all ones and drops the trigger pin. It then raises `tick` for exactly the cycle in which the edge detector fires, which is two edges after the pin is first sampled. It judges the result by reading back the counter and the capture pair and by checking that both flags are set. This is done once in reload use and once in capture use.

// File: rtl/cr_timer_pkg.sv
package cr_timer_pkg;

    typedef enum logic [1:0] {
        ST_STOP    = 2'd0,
        ST_RELOAD  = 2'd1,
        ST_CAPTURE = 2'd2,
        ST_BAUD    = 2'd3
    } tmr_state_e;

    localparam int CTRL_RUN    = 0;
    localparam int CTRL_CNTMD  = 1;
    localparam int CTRL_CAPSEL = 2;
    localparam int CTRL_EXTEN  = 3;
    localparam int CTRL_RXCLK  = 4;
    localparam int CTRL_TXCLK  = 5;
    localparam int CTRL_OVF    = 6;
    localparam int CTRL_EXT    = 7;

    typedef struct packed {
        logic count_on;
        logic ovf_reload;
        logic ovf_flag_ok;
        logic trig_capture;
        logic trig_reload;
        logic baud_out;
    } mode_ctl_t;

endpackage

// File: rtl/cr_pin_edge.sv
module cr_pin_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic fall
);

    logic [STAGES:0] shreg;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg <= '0;
        end else begin
            shreg <= {shreg[STAGES-1:0], pin};
        end
    end

    assign fall = shreg[STAGES] & ~shreg[STAGES-1];

endmodule

// File: rtl/cr_mode_fsm.sv
module cr_mode_fsm
    import cr_timer_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic       capsel,
    input  logic       rxclk,
    input  logic       txclk,
    output tmr_state_e state,
    output mode_ctl_t  ctl
);

    tmr_state_e state_nxt;

    always_comb begin
        if (!run) begin
            state_nxt = ST_STOP;
        end else if (rxclk || txclk) begin
            state_nxt = ST_BAUD;
        end else if (capsel) begin
            state_nxt = ST_CAPTURE;
        end else begin
            state_nxt = ST_RELOAD;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_STOP;
        end else begin
            state <= state_nxt;
        end
    end

    always_comb begin
        ctl = '0;
        unique case (state)
            ST_STOP: begin
                ctl = '0;
            end
            ST_RELOAD: begin
                ctl.count_on    = 1'b1;
                ctl.ovf_reload  = 1'b1;
                ctl.ovf_flag_ok = 1'b1;
                ctl.trig_reload = 1'b1;
            end
            ST_CAPTURE: begin
                ctl.count_on     = 1'b1;
                ctl.ovf_flag_ok  = 1'b1;
                ctl.trig_capture = 1'b1;
            end
            ST_BAUD: begin
                ctl.count_on   = 1'b1;
                ctl.ovf_reload = 1'b1;
                ctl.baud_out   = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/cr_count_core.sv
module cr_count_core
    import cr_timer_pkg::*;
#(
    parameter int CNT_W = 16,
    localparam int NB = CNT_W / 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  mode_ctl_t        ctl,
    input  logic             adv,
    input  logic             trig,
    input  logic             ext_en,
    input  logic [NB-1:0]    cnt_we,
    input  logic [NB-1:0]    cap_we,
    input  logic [7:0]       wr_data,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] cap,
    output logic             ovf_evt,
    output logic             ext_evt,
    output logic             baud_tick
);

    logic [CNT_W-1:0] cnt_nxt;
    logic [CNT_W-1:0] cap_nxt;
    logic             step;
    logic             wrap;
    logic             hit_cap;
    logic             hit_rld;

    always_comb begin
        step    = ctl.count_on & adv;
        wrap    = step & (&count);
        hit_cap = trig & ext_en & ctl.trig_capture;
        hit_rld = trig & ext_en & ctl.trig_reload;

        cnt_nxt = count;
        if (step) begin
            cnt_nxt = count + 1'b1;
        end
        if ((wrap && ctl.ovf_reload) || hit_rld) begin
            cnt_nxt = cap;
        end
        for (int i = 0; i < NB; i++) begin
            if (cnt_we[i]) begin
                cnt_nxt[8*i +: 8] = wr_data;
            end
        end

        cap_nxt = cap;
        if (hit_cap) begin
            cap_nxt = count;
        end
        for (int i = 0; i < NB; i++) begin
            if (cap_we[i]) begin
                cap_nxt[8*i +: 8] = wr_data;
            end
        end

        ovf_evt = wrap & ctl.ovf_flag_ok;
        ext_evt = hit_cap | hit_rld;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count     <= '0;
            cap       <= '0;
            baud_tick <= 1'b0;
        end else begin
            count     <= cnt_nxt;
            cap       <= cap_nxt;
            baud_tick <= wrap & ctl.baud_out;
        end
    end

endmodule

// File: rtl/cr_timer.sv
module cr_timer
    import cr_timer_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 3,
    parameter int SYNC_N = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              cnt_pin,
    input  logic              trig_pin,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wr_data,
    output logic [7:0]        rd_data,
    input  logic              irq_en,
    output logic              ovf_flag,
    output logic              ext_flag,
    output logic              irq,
    output logic              baud_tick
);

    localparam int NB = CNT_W / 8;

    logic [7:0]       ctrl_q;
    logic [1:0]       pin_raw;
    logic [1:0]       pin_fall;
    logic [NB-1:0]    cnt_we;
    logic [NB-1:0]    cap_we;
    logic [CNT_W-1:0] count_q;
    logic [CNT_W-1:0] cap_q;
    logic             ovf_evt;
    logic             ext_evt;
    logic             adv;
    tmr_state_e       state;
    mode_ctl_t        ctl;

    assign pin_raw = {trig_pin, cnt_pin};

    for (genvar g = 0; g < 2; g++) begin : g_pin
        cr_pin_edge #(.STAGES(SYNC_N)) u_edge (
            .clk   (clk),
            .rst_n (rst_n),
            .pin   (pin_raw[g]),
            .fall  (pin_fall[g])
        );
    end

    cr_mode_fsm u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (ctrl_q[CTRL_RUN]),
        .capsel (ctrl_q[CTRL_CAPSEL]),
        .rxclk  (ctrl_q[CTRL_RXCLK]),
        .txclk  (ctrl_q[CTRL_TXCLK]),
        .state  (state),
        .ctl    (ctl)
    );

    always_comb begin
        for (int i = 0; i < NB; i++) begin
            cnt_we[i] = wr_en && (addr == ADDR_W'(1 + i));
            cap_we[i] = wr_en && (addr == ADDR_W'(1 + NB + i));
        end
    end

    assign adv = ctrl_q[CTRL_CNTMD] ? pin_fall[0] : tick;

    cr_count_core #(.CNT_W(CNT_W)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl       (ctl),
        .adv       (adv),
        .trig      (pin_fall[1]),
        .ext_en    (ctrl_q[CTRL_EXTEN]),
        .cnt_we    (cnt_we),
        .cap_we    (cap_we),
        .wr_data   (wr_data),
        .count     (count_q),
        .cap       (cap_q),
        .ovf_evt   (ovf_evt),
        .ext_evt   (ext_evt),
        .baud_tick (baud_tick)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else begin
            if (wr_en && addr == '0) begin
                ctrl_q <= wr_data;
            end
            if (ovf_evt) begin
                ctrl_q[CTRL_OVF] <= 1'b1;
            end
            if (ext_evt) begin
                ctrl_q[CTRL_EXT] <= 1'b1;
            end
        end
    end

    always_comb begin
        rd_data = '0;
        if (addr == '0) begin
            rd_data = ctrl_q;
        end
        for (int i = 0; i < NB; i++) begin
            if (addr == ADDR_W'(1 + i)) begin
                rd_data = count_q[8*i +: 8];
            end
            if (addr == ADDR_W'(1 + NB + i)) begin
                rd_data = cap_q[8*i +: 8];
            end
        end
    end

    assign ovf_flag = ctrl_q[CTRL_OVF];
    assign ext_flag = ctrl_q[CTRL_EXT];
    assign irq      = irq_en & (ovf_flag | ext_flag);

endmodule

// File: rtl/cr_timer_chk.sv
module cr_timer_chk
    import cr_timer_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic              irq_en,
    input logic              ovf_flag,
    input logic              ext_flag,
    input logic              irq,
    input logic              baud_tick,
    input logic              trig_fall,
    input tmr_state_e        state,
    input logic [CNT_W-1:0]  count
);

    assert_irq_needs_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(ovf_flag || ext_flag) |-> !irq);

    assert_irq_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |-> !irq);

    assert_baud_no_ovf_R8: assert property (@(posedge clk) disable iff (!rst_n)
        baud_tick |-> !$rose(ovf_flag));

    assert_ext_from_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ext_flag) && !$past(wr_en && addr == '0)) |-> $past(trig_fall));

    assert_stop_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STOP && !wr_en) |=> $stable(count));

    assert_ovf_from_top_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ovf_flag) && !$past(wr_en && addr == '0)) |-> ($past(count) == {CNT_W{1'b1}}));

endmodule

bind cr_timer cr_timer_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .addr      (addr),
    .irq_en    (irq_en),
    .ovf_flag  (ovf_flag),
    .ext_flag  (ext_flag),
    .irq       (irq),
    .baud_tick (baud_tick),
    .trig_fall (pin_fall[1]),
    .state     (state),
    .count     (count_q)
);

// File: tb/cr_timer_bench.sv
module cr_timer_bench;

    localparam int CLK_PERIOD = 10;

    localparam logic [7:0] C_RUN = 8'h01;
    localparam logic [7:0] C_CNT = 8'h02;
    localparam logic [7:0] C_CAP = 8'h04;
    localparam logic [7:0] C_EXT = 8'h08;
    localparam logic [7:0] C_RX  = 8'h10;
    localparam logic [7:0] C_TX  = 8'h20;

    typedef struct packed {
        logic [15:0] cap;
        logic [15:0] start;
        logic [7:0]  n;
        logic [15:0] exp_cnt;
        logic        exp_ovf;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{16'h0000, 16'h0000, 8'd5, 16'h0005, 1'b0},
        '{16'h1234, 16'hFFFE, 8'd3, 16'h1235, 1'b1},
        '{16'hFFF0, 16'hFFFF, 8'd1, 16'hFFF0, 1'b1},
        '{16'h00FF, 16'h00FD, 8'd4, 16'h0101, 1'b0},
        '{16'hFFFF, 16'hFFFF, 8'd3, 16'hFFFF, 1'b1},
        '{16'hABCD, 16'hFFFD, 8'd6, 16'hABD0, 1'b1}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       cnt_pin = 1'b0;
    logic       trig_pin = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] addr = '0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       irq_en = 1'b0;
    logic       ovf_flag;
    logic       ext_flag;
    logic       irq;
    logic       baud_tick;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cr_timer u_cr_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .cnt_pin   (cnt_pin),
        .trig_pin  (trig_pin),
        .wr_en     (wr_en),
        .addr      (addr),
        .wr_data   (wr_data),
        .rd_data   (rd_data),
        .irq_en    (irq_en),
        .ovf_flag  (ovf_flag),
        .ext_flag  (ext_flag),
        .irq       (irq),
        .baud_tick (baud_tick)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic set16(input logic [2:0] base, input logic [15:0] v);
        wr(base, v[7:0]);
        wr(base + 3'd1, v[15:8]);
    endtask

    task automatic ctrl(input logic [7:0] d);
        wr(3'd0, d);
        @(negedge clk);
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic rd16(input logic [2:0] base, output logic [15:0] v);
        logic [7:0] lo, hi;
        rd(base, lo);
        rd(base + 3'd1, hi);
        v = {hi, lo};
    endtask

    task automatic tick_n(input int n);
        tick = 1'b1;
        repeat (n) @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic trig_event(input bit with_tick);
        trig_pin = 1'b1;
        repeat (4) @(negedge clk);
        trig_pin = 1'b0;
        @(negedge clk);
        @(negedge clk);
        tick = with_tick;
        @(negedge clk);
        tick = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog: actual hung expected finished");
        summary();
    end

    initial begin
        logic [15:0] v;
        logic [7:0]  b;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state and address map
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), b);
            chk("R1 reset read", {24'd0, b}, 32'd0);
        end
        chk("R1 reset flags", {28'd0, ovf_flag, ext_flag, irq, baud_tick}, 32'd0);

        // R4: reload-on-overflow vectors in timer mode
        foreach (VECS[k]) begin
            ctrl(8'h00);
            set16(3'd3, VECS[k].cap);
            set16(3'd1, VECS[k].start);
            ctrl(C_RUN);
            tick_n(int'(VECS[k].n));
            rd16(3'd1, v);
            chk("R4 reload count", {16'd0, v}, {16'd0, VECS[k].exp_cnt});
            chk("R4 overflow flag", {31'd0, ovf_flag}, {31'd0, VECS[k].exp_ovf});
        end

        // R2: stopped counter ignores ticks and pins
        ctrl(8'h00);
        set16(3'd1, 16'h0042);
        tick_n(5);
        trig_event(1'b1);
        rd16(3'd1, v);
        chk("R2 stopped hold", {16'd0, v}, 32'h0042);

        // R3: counter mode counts falling edges and ignores tick
        set16(3'd1, 16'h0000);
        ctrl(C_RUN | C_CNT);
        for (int e = 0; e < 4; e++) begin
            cnt_pin = 1'b1;
            repeat (3) @(negedge clk);
            cnt_pin = 1'b0;
            repeat (3) @(negedge clk);
        end
        tick_n(3);
        rd16(3'd1, v);
        chk("R3 counter mode", {16'd0, v}, 32'h0004);

        // R5: capture of running count
        ctrl(8'h00);
        set16(3'd3, 16'h0000);
        set16(3'd1, 16'h0100);
        ctrl(C_RUN | C_CAP | C_EXT);
        tick_n(2);
        trig_event(1'b0);
        rd16(3'd3, v);
        chk("R5 captured value", {16'd0, v}, 32'h0102);
        chk("R5 external flag", {31'd0, ext_flag}, 32'd1);
        tick_n(1);
        rd16(3'd1, v);
        chk("R5 keeps counting", {16'd0, v}, 32'h0103);

        // R10: interrupt gating
        irq_en = 1'b1; #1;
        chk("R10 irq enabled", {31'd0, irq}, 32'd1);
        irq_en = 1'b0; #1;
        chk("R10 irq disabled", {31'd0, irq}, 32'd0);

        // R9: sticky flag, cleared by writing 0
        repeat (5) @(negedge clk);
        rd(3'd0, b);
        chk("R9 flag sticky", {24'd0, b}, 32'h8D);
        ctrl(C_RUN | C_CAP | C_EXT);
        chk("R9 flag cleared", {31'd0, ext_flag}, 32'd0);

        // R7: trigger enable off
        ctrl(C_RUN | C_CAP);
        set16(3'd1, 16'h0500);
        trig_event(1'b0);
        rd16(3'd3, v);
        chk("R7 no capture", {16'd0, v}, 32'h0102);
        chk("R7 no flag capture", {31'd0, ext_flag}, 32'd0);
        ctrl(C_RUN);
        trig_event(1'b0);
        rd16(3'd1, v);
        chk("R7 no reload", {16'd0, v}, 32'h0500);
        chk("R7 no flag reload", {31'd0, ext_flag}, 32'd0);

        // R6: trigger-driven reload
        ctrl(8'h00);
        set16(3'd3, 16'h4000);
        set16(3'd1, 16'h0010);
        ctrl(C_RUN | C_EXT);
        trig_event(1'b0);
        rd16(3'd1, v);
        chk("R6 trigger reload", {16'd0, v}, 32'h4000);
        chk("R6 flags", {30'd0, ext_flag, ovf_flag}, 32'h2);

        // R8: baud use via receive clock, capture select and trigger ignored
        ctrl(8'h00);
        set16(3'd3, 16'hFFFE);
        set16(3'd1, 16'hFFFE);
        ctrl(C_RUN | C_CAP | C_EXT | C_RX);
        tick = 1'b1;
        @(negedge clk);
        @(negedge clk);
        tick = 1'b0;
        #1;
        chk("R8 baud pulse", {31'd0, baud_tick}, 32'd1);
        @(negedge clk); #1;
        chk("R8 baud one cycle", {31'd0, baud_tick}, 32'd0);
        rd16(3'd1, v);
        chk("R8 baud reload", {16'd0, v}, 32'hFFFE);
        chk("R8 no overflow flag", {31'd0, ovf_flag}, 32'd0);
        trig_event(1'b0);
        rd16(3'd3, v);
        chk("R8 trigger ignored cap", {16'd0, v}, 32'hFFFE);
        chk("R8 trigger ignored flag", {31'd0, ext_flag}, 32'd0);

        // R8: transmit clock variant
        ctrl(8'h00);
        set16(3'd3, 16'h7000);
        set16(3'd1, 16'hFFFF);
        ctrl(C_RUN | C_TX);
        tick_n(1);
        #1;
        chk("R8 tx baud pulse", {31'd0, baud_tick}, 32'd1);
        rd16(3'd1, v);
        chk("R8 tx reload", {16'd0, v}, 32'h7000);
        chk("R8 tx no overflow flag", {31'd0, ovf_flag}, 32'd0);

        // R11: coincident trigger reload and overflow
        ctrl(8'h00);
        set16(3'd3, 16'h2222);
        set16(3'd1, 16'hFFFF);
        ctrl(C_RUN | C_EXT);
        trig_event(1'b1);
        rd16(3'd1, v);
        chk("R11 reload count", {16'd0, v}, 32'h2222);
        chk("R11 reload flags", {30'd0, ext_flag, ovf_flag}, 32'h3);

        // R11: coincident capture and overflow
        ctrl(8'h00);
        set16(3'd3, 16'h0000);
        set16(3'd1, 16'hFFFF);
        ctrl(C_RUN | C_CAP | C_EXT);
        trig_event(1'b1);
        rd16(3'd3, v);
        chk("R11 capture value", {16'd0, v}, 32'hFFFF);
        rd16(3'd1, v);
        chk("R11 capture wrap", {16'd0, v}, 32'h0000);
        chk("R11 capture flags", {30'd0, ext_flag, ovf_flag}, 32'h3);

        summary();
    end

endmodule